// File: doc/BRIEF.md
# I2C Slave Address Matcher with General Call

This block sits on the receive side of an I2C slave. It watches the clock and data lines, which have already been brought into the system clock domain. It spots START and STOP conditions and shifts in the first byte after each START. That byte is compared with a programmed seven-bit own address. When general call is enabled, the byte is also compared with the fixed all-zero broadcast address. When the byte matches, the block loads it into a one-byte receive buffer, pulls SDA low for the acknowledge clock and raises an interrupt flag. Every later byte of the same transfer is received, acknowledged and flagged in the same way.

The host tells an own-address hit from a general call by reading the buffered byte. An own-address hit shows the address in bits 7:1 and the direction bit in bit 0. A general call shows 0x00. Two status bits record whether the last bus condition was a START or a STOP, and a bus-free output is derived from them. In ten-bit mode the seven-bit own-address compare is switched off. A general call is still recognised there, and reception moves straight to data without waiting for a second address byte.

Top module: `i2c_addr_matcher`

## Requirements
- R1: A START (SDA falls while SCL stays high) sets `startSeen` and clears `stopSeen`. A STOP (SDA rises while SCL stays high) sets `stopSeen` and clears `startSeen`. Both are 0 after reset.
- R2: `busFree` is 1 when `stopSeen` is 1, or when both `startSeen` and `stopSeen` are 0. Otherwise it is 0.
- R3: The first byte after a START is shifted in MSB first, one bit per SCL rising edge. It matches when its bits 7:1 equal `ownAddr` in seven-bit mode, whatever bit 0 is. It also matches when it is 0x00 and `gcEnable` is 1. A byte of 0x00 with `gcEnable` at 0, or 0x01, is no general call.
- R4: For an accepted byte, `rxByte` takes the whole byte and `bufFull` goes to 1 in the cycle after the eighth SCL rising edge is seen. A `bufRead` pulse clears `bufFull`.
- R5: For an accepted byte, `sdaPullLow` is 1 from the SCL falling edge after the eighth bit until the SCL falling edge that ends the ninth clock. At all other times it is 0.
- R6: `irqFlag` is set at the SCL falling edge that ends the ninth clock of every matched byte. `flagClear` clears both `irqFlag` and `overflow`.
- R7: A STOP, or a repeated START, clears any address or byte progress and releases `sdaPullLow`. A byte cut short by a STOP leaves no trace on the next transfer.
- R8: If `bufFull` is still 1 when a matched byte completes, `overflow` is set, `rxByte` keeps its old value, and no ACK is driven. `irqFlag` is still raised.
- R9: After a non-matching address, SDA stays released in the ninth clock. Later bytes change neither the buffer nor the flags until the next START or STOP.
- R10: With `tenBitMode` at 1, an own-address byte is not matched. A general call is matched, and the byte that follows it is taken as data.
- R11: After a match, each further byte is loaded, acknowledged and flagged as in R4 to R6, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| ownAddr | input | 7 | Programmed own address |
| gcEnable | input | 1 | Accept the general call address |
| tenBitMode | input | 1 | Ten-bit mode: own seven-bit compare off |
| bufRead | input | 1 | Host read strobe, clears bufFull |
| flagClear | input | 1 | Clears irqFlag and overflow |
| sdaPullLow | output | 1 | Drive SDA low (ACK) |
| rxByte | output | 8 | Receive buffer |
| bufFull | output | 1 | Receive buffer holds an unread byte |
| irqFlag | output | 1 | Byte-complete interrupt flag |
| overflow | output | 1 | Matched byte dropped, buffer was full |
| startSeen | output | 1 | Last condition was START |
| stopSeen | output | 1 | Last condition was STOP |
| busFree | output | 1 | Bus is free to claim |

## Verification
The bench covers several corner cases, and each one names what a faulty design would do:

- **General call with the enable low.** A design that ignores `gcEnable` would acknowledge the zero byte.
- **Zero byte with bit 0 set.** A design that compares only bits 7:1 for the broadcast address would acknowledge it.
- **Own address in ten-bit mode.** A design that keeps the seven-bit compare active there would acknowledge it.
- **Data byte after a ten-bit general call.** A design that waits for a second address byte would drop it.
- **Byte arriving while the buffer is still full.** A faulty design would overwrite `rxByte` or still drive ACK.
- **Non-matching address followed by more bytes.** A design that does not lock out until the next START or STOP would load those bytes.
- **Byte cut short by a STOP, then a clean transfer.** Stale bit-count state would misalign the next address.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } matchState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic shiftEn;
    logic loadBuf;
  } dpStrobe_t;

  // datapath -> control bus events
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic sclFall;
  } busEvent_t;

endpackage

// File: rtl/i2cam_datapath.sv
module i2cam_datapath
  import i2cam_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  input  logic              bufRead,
  output busEvent_t         ev,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] nextByte,
  output logic [BYTE_W-1:0] rxByte,
  output logic              bufFull
);

  logic sclD;
  logic sdaD;
  logic [BYTE_W-1:0] shReg;

  // previous line levels; an idle bus is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclIn;
      sdaD <= sdaIn;
    end
  end

  always_comb begin
    ev.startDet = sclIn & sclD & sdaD & ~sdaIn;
    ev.stopDet  = sclIn & sclD & ~sdaD & sdaIn;
    ev.sclRise  = sclIn & ~sclD;
    ev.sclFall  = ~sclIn & sclD;
  end

  assign nextByte = {shReg[BYTE_W-2:0], sdaIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else begin
      if (strobe.cntClr) begin
        bitCnt <= '0;
      end else if (strobe.cntInc) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobe.shiftEn) begin
        shReg <= nextByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      bufFull <= 1'b0;
    end else if (strobe.loadBuf) begin
      rxByte  <= nextByte;
      bufFull <= 1'b1;
    end else if (bufRead) begin
      bufFull <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cam_control.sv
module i2cam_control
  import i2cam_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] nextByte,
  input  logic              bufFull,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              tenBitMode,
  input  logic              flagClear,
  output dpStrobe_t         strobe,
  output logic              sdaPullLow,
  output logic              irqFlag,
  output logic              overflow,
  output logic              startSeen,
  output logic              stopSeen
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_WAIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CLK  = CNT_W'(BYTE_W + 1);

  matchState_t state;
  logic ackArmed;
  logic irqPend;
  logic active;
  logic busCond;
  logic byteDone;
  logic ownHit;
  logic gcHit;
  logic matched;

  assign active   = (state == ST_ADDR) || (state == ST_DATA);
  assign busCond  = ev.startDet | ev.stopDet;
  assign byteDone = active && !busCond && ev.sclRise && (bitCnt == LAST_BIT);
  assign ownHit   = !tenBitMode && (nextByte[BYTE_W-1:1] == ownAddr);
  assign gcHit    = gcEnable && (nextByte == '0);
  assign matched  = (state == ST_DATA) || ownHit || gcHit;

  always_comb begin
    strobe = '0;
    if (busCond) begin
      strobe.cntClr = 1'b1;
    end else if (active) begin
      if (ev.sclRise && (bitCnt < ACK_WAIT)) begin
        strobe.shiftEn = 1'b1;
        strobe.cntInc  = 1'b1;
      end else if (ev.sclRise && (bitCnt == ACK_WAIT)) begin
        strobe.cntInc = 1'b1;
      end else if (ev.sclFall && (bitCnt == ACK_CLK)) begin
        strobe.cntClr = 1'b1;
      end
    end
    strobe.loadBuf = byteDone && matched && !bufFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      sdaPullLow <= 1'b0;
      ackArmed   <= 1'b0;
      irqPend    <= 1'b0;
      irqFlag    <= 1'b0;
      overflow   <= 1'b0;
      startSeen  <= 1'b0;
      stopSeen   <= 1'b0;
    end else begin
      if (flagClear) begin
        irqFlag  <= 1'b0;
        overflow <= 1'b0;
      end
      if (ev.startDet) begin
        state      <= ST_ADDR;
        startSeen  <= 1'b1;
        stopSeen   <= 1'b0;
        sdaPullLow <= 1'b0;
        ackArmed   <= 1'b0;
        irqPend    <= 1'b0;
      end else if (ev.stopDet) begin
        state      <= ST_IDLE;
        startSeen  <= 1'b0;
        stopSeen   <= 1'b1;
        sdaPullLow <= 1'b0;
        ackArmed   <= 1'b0;
        irqPend    <= 1'b0;
      end else if (active) begin
        if (byteDone) begin
          if (matched) begin
            state    <= ST_DATA;
            irqPend  <= 1'b1;
            ackArmed <= !bufFull;
            if (bufFull) begin
              overflow <= 1'b1;
            end
          end else begin
            state <= ST_SKIP;
          end
        end
        if (ev.sclFall && (bitCnt == ACK_WAIT) && ackArmed) begin
          sdaPullLow <= 1'b1;
          ackArmed   <= 1'b0;
        end
        if (ev.sclFall && (bitCnt == ACK_CLK)) begin
          sdaPullLow <= 1'b0;
          if (irqPend) begin
            irqFlag <= 1'b1;
            irqPend <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2cam_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              gcEnable,
  input  logic              tenBitMode,
  input  logic              bufRead,
  input  logic              flagClear,
  output logic              sdaPullLow,
  output logic [BYTE_W-1:0] rxByte,
  output logic              bufFull,
  output logic              irqFlag,
  output logic              overflow,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              busFree
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  busEvent_t         ev;
  dpStrobe_t         strobe;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] nextByte;

  i2cam_datapath #(
    .BYTE_W(BYTE_W),
    .CNT_W (CNT_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strobe  (strobe),
    .bufRead (bufRead),
    .ev      (ev),
    .bitCnt  (bitCnt),
    .nextByte(nextByte),
    .rxByte  (rxByte),
    .bufFull (bufFull)
  );

  i2cam_control #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W),
    .CNT_W (CNT_W)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .ev        (ev),
    .bitCnt    (bitCnt),
    .nextByte  (nextByte),
    .bufFull   (bufFull),
    .ownAddr   (ownAddr),
    .gcEnable  (gcEnable),
    .tenBitMode(tenBitMode),
    .flagClear (flagClear),
    .strobe    (strobe),
    .sdaPullLow(sdaPullLow),
    .irqFlag   (irqFlag),
    .overflow  (overflow),
    .startSeen (startSeen),
    .stopSeen  (stopSeen)
  );

  assign busFree = stopSeen | ~(startSeen | stopSeen);

endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              irqFlag,
  input logic              overflow,
  input logic              startSeen,
  input logic              stopSeen,
  input logic [BYTE_W-1:0] rxByte
);

  AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen)); // R1

  AST_ACK_AT_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !$past(sclIn)); // R5

  AST_IRQ_AT_SCL_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !$past(sclIn)); // R6

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopSeen) |-> !sdaPullLow); // R7

  AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $stable(rxByte)); // R8

endmodule

bind i2c_addr_matcher i2cam_checker #(.BYTE_W(BYTE_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaPullLow(sdaPullLow),
  .irqFlag   (irqFlag),
  .overflow  (overflow),
  .startSeen (startSeen),
  .stopSeen  (stopSeen),
  .rxByte    (rxByte)
);

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic [6:0] ownAddr = 7'h3A;
  logic gcEnable = 1'b0;
  logic tenBitMode = 1'b0;
  logic bufRead = 1'b0;
  logic flagClear = 1'b0;
  logic sdaPullLow;
  logic [7:0] rxByte;
  logic bufFull, irqFlag, overflow, startSeen, stopSeen, busFree;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_addr_matcher uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .gcEnable(gcEnable), .tenBitMode(tenBitMode), .bufRead(bufRead),
    .flagClear(flagClear), .sdaPullLow(sdaPullLow), .rxByte(rxByte),
    .bufFull(bufFull), .irqFlag(irqFlag), .overflow(overflow),
    .startSeen(startSeen), .stopSeen(stopSeen), .busFree(busFree)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mPrevScl, mPrevSda, mS, mP, mDrive, mFull, mIrq, mOvf, mAccept, mHad;
  int mMode;   // 0 idle, 1 address, 2 data, 3 ignoring
  int mPhase;  // 0 collecting bits, 1 waiting for ack clock, 2 in ack clock
  bit mBits[$];
  logic [7:0] mBuf;

  always @(posedge clk) begin
    if (!rstN) begin
      mPrevScl = 1; mPrevSda = 1; mS = 0; mP = 0; mDrive = 0; mFull = 0;
      mIrq = 0; mOvf = 0; mAccept = 0; mHad = 0; mMode = 0; mPhase = 0;
      mBits.delete(); mBuf = 8'h00;
    end else begin
      bit rise, fall, st, sp, hit;
      logic [7:0] b;
      rise = sclIn && !mPrevScl;
      fall = !sclIn && mPrevScl;
      st = sclIn && mPrevScl && mPrevSda && !sdaIn;
      sp = sclIn && mPrevScl && !mPrevSda && sdaIn;
      if (bufRead) mFull = 0;
      if (flagClear) begin mIrq = 0; mOvf = 0; end
      if (st || sp) begin
        mS = st; mP = sp; mMode = st ? 1 : 0;
        mBits.delete(); mPhase = 0; mDrive = 0; mAccept = 0; mHad = 0;
      end else if (mMode == 1 || mMode == 2) begin
        if (rise && mPhase == 0) begin
          mBits.push_back(sdaIn);
          if (mBits.size() == 8) begin
            for (int i = 0; i < 8; i++) b[7-i] = mBits[i];
            hit = (mMode == 2) || (!tenBitMode && b[7:1] == ownAddr) ||
                  (gcEnable && b == 8'h00);
            if (hit) begin
              mHad = 1; mMode = 2;
              if (mFull) begin mOvf = 1; mAccept = 0; end
              else begin mBuf = b; mFull = 1; mAccept = 1; end
            end else begin
              mHad = 0; mMode = 3;
            end
            mPhase = 1;
            mBits.delete();
          end
        end else if (fall && mPhase == 1) begin
          if (mAccept) mDrive = 1;
          mAccept = 0;
        end else if (rise && mPhase == 1) begin
          mPhase = 2;
        end else if (fall && mPhase == 2) begin
          mDrive = 0;
          if (mHad) mIrq = 1;
          mHad = 0;
          mPhase = 0;
        end
      end
      mPrevScl = sclIn;
      mPrevSda = sdaIn;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(sdaPullLow == mDrive, "R5 sdaPullLow", sdaPullLow, mDrive);
      check(bufFull == mFull, "R4 bufFull", bufFull, mFull);
      check(rxByte == mBuf, "R4 rxByte", rxByte, mBuf);
      check(irqFlag == mIrq, "R6 irqFlag", irqFlag, mIrq);
      check(overflow == mOvf, "R8 overflow", overflow, mOvf);
      check(startSeen == mS && stopSeen == mP, "R1 start/stop bits",
            {startSeen, stopSeen}, {mS, mP});
      check(busFree == (mP || (!mS && !mP)), "R2 busFree", busFree, mP || (!mS && !mP));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaIn = 1; waitN(4); sclIn = 1; waitN(4); sdaIn = 0; waitN(4); sclIn = 0; waitN(4);
  endtask

  task automatic stopCond();
    sdaIn = 0; waitN(4); sclIn = 1; waitN(4); sdaIn = 1; waitN(4);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaIn = b[i]; waitN(4); sclIn = 1; waitN(4); sclIn = 0; waitN(4);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaIn = 1; waitN(4); sclIn = 1; waitN(2);
    ack = sdaPullLow;
    waitN(2); sclIn = 0; waitN(4);
  endtask

  task automatic pulseRead();
    bufRead = 1; waitN(1); bufRead = 0; waitN(1);
  endtask

  task automatic pulseClear();
    flagClear = 1; waitN(1); flagClear = 0; waitN(1);
  endtask

  initial begin
    bit ack;
    waitN(3);
    rstN = 1;
    waitN(2);
    check(!startSeen && !stopSeen && busFree, "R1 R2 reset state", {startSeen, stopSeen, busFree}, 3'b001);
    check(!bufFull && !irqFlag && !sdaPullLow, "R4 reset flags", {bufFull, irqFlag, sdaPullLow}, 0);

    // own address, then data, then overflow
    startCond();
    check(startSeen && !busFree, "R1 R2 start seen", {startSeen, busFree}, 2'b10);
    sendByte(8'h74, ack);
    check(ack == 1, "R3 R5 own address acked", ack, 1);
    check(rxByte == 8'h74 && bufFull, "R4 own address byte", rxByte, 8'h74);
    check(irqFlag == 1, "R6 irq after address", irqFlag, 1);
    pulseRead(); pulseClear();
    sendByte(8'hC5, ack);
    check(ack == 1 && rxByte == 8'hC5, "R11 data byte accepted", rxByte, 8'hC5);
    sendByte(8'h11, ack);
    check(ack == 0, "R8 no ack on overflow", ack, 0);
    check(overflow && rxByte == 8'hC5, "R8 overflow keeps buffer", rxByte, 8'hC5);
    pulseClear();
    check(!overflow && !irqFlag, "R6 flagClear", {overflow, irqFlag}, 0);
    stopCond();
    check(stopSeen && busFree && !startSeen, "R1 R2 stop seen", {stopSeen, busFree}, 2'b11);
    pulseRead();

    // general call disabled: ignored, following bytes ignored
    startCond();
    sendByte(8'h00, ack);
    check(ack == 0 && !bufFull, "R3 general call disabled", ack, 0);
    sendByte(8'h74, ack);
    check(ack == 0 && !bufFull && !irqFlag, "R9 bytes after mismatch ignored", bufFull, 0);
    stopCond();

    // general call enabled
    gcEnable = 1;
    startCond();
    sendByte(8'h00, ack);
    check(ack == 1 && rxByte == 8'h00 && bufFull, "R3 general call matched", rxByte, 0);
    pulseRead(); pulseClear();
    sendByte(8'h5A, ack);
    check(ack == 1 && rxByte == 8'h5A, "R11 data after general call", rxByte, 8'h5A);
    pulseRead(); pulseClear();
    // repeated start with 0x01: not a general call
    startCond();
    sendByte(8'h01, ack);
    check(ack == 0 && !bufFull, "R3 zero address with read bit", ack, 0);
    stopCond();

    // ten-bit mode
    tenBitMode = 1;
    startCond();
    sendByte(8'h74, ack);
    check(ack == 0 && !bufFull, "R10 own address off in ten-bit mode", ack, 0);
    startCond();
    check(startSeen, "R7 repeated start", startSeen, 1);
    sendByte(8'h00, ack);
    check(ack == 1, "R10 general call in ten-bit mode", ack, 1);
    pulseRead();
    sendByte(8'h3C, ack);
    check(ack == 1 && rxByte == 8'h3C, "R10 next byte is data", rxByte, 8'h3C);
    pulseRead(); pulseClear();
    stopCond();
    tenBitMode = 0;

    // byte cut by STOP, then clean transfer
    startCond();
    sendBits(8'hF0, 4);
    stopCond();
    check(!sdaPullLow && !bufFull, "R7 stop aborts byte", bufFull, 0);
    startCond();
    sendByte(8'h75, ack);
    check(ack == 1 && rxByte == 8'h75, "R7 clean transfer after abort", rxByte, 8'h75);
    stopCond();
    waitN(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule